// File: doc/BRIEF.md
# DFI Controller-Update Request Sequencer

This block runs the controller-update handshake that a DDR memory controller holds with its PHY over the DFI boundary. It raises an update request, watches the PHY acknowledge, and lowers the request under a programmable minimum and maximum hold time. When the PHY stays silent, the block abandons the request at a fixed point after the minimum window and flags a timeout.

A handshake can start from three sources:
- an internal interval timer, which can be switched off;
- a one-cycle software command;
- the self-refresh exit sequence.

Around self-refresh exit the update can be placed ahead of the exit, or it can follow it. In the first case the block holds a ready output low toward the self-refresh sequencer until the handshake has completed. In the second case the block starts the request as soon as the sequencer reports that the exit is done. A separate control suppresses all exit-related updates.

Requests that arrive while a handshake is running are remembered and served once the current handshake has ended.

Top module: `dfi_upd_seq`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `upd_req` and `upd_timeout` are low and `srx_ready` is high.
- R2: When idle, a high `sw_upd` sampled at a clock edge makes `upd_req` high from that edge on.
- R3: If `phy_ack` is never sampled high while the request has been high for `cfg_t_min` cycles or fewer, `upd_req` stays high exactly `cfg_t_min`+2 cycles. `upd_timeout` is then high for the single cycle after the fall.
- R4: If `phy_ack` is sampled high within the first `cfg_t_min` request cycles, the request ends at the first cycle that is at least `cfg_t_min` and in which `phy_ack` is sampled low. That handshake raises no timeout.
- R5: `upd_req` is never high for more than `cfg_t_max` consecutive cycles. When the acknowledge is held high, the request lasts exactly `cfg_t_max` cycles.
- R6: An acknowledge that first appears after request cycle `cfg_t_min` is ignored, and the handshake ends as in R3.
- R7: With `cfg_dis_auto` low, an idle block raises `upd_req` every `UPD_INTERVAL` cycles.
- R8: With `cfg_dis_auto` high, no request is raised without a software or self-refresh trigger.
- R9: A trigger that arrives during a handshake is held. After the current request falls, `upd_req` is low for exactly one cycle and then rises for the held trigger.
- R10: With `cfg_pre_srx`=1 and `cfg_dis_srx_upd`=0, a sampled `srx_exit_req` drives `srx_ready` low and starts a request at the same edge. `srx_ready` returns high at the edge where that request falls.
- R11: With `cfg_pre_srx`=0 and `cfg_dis_srx_upd`=0, `srx_exit_req` leaves `srx_ready` high and starts nothing. `upd_req` rises at the edge that samples `srx_done` high.
- R12: With `cfg_dis_srx_upd`=1, neither `srx_exit_req` nor `srx_done` starts a request, whatever `cfg_pre_srx` holds, and `srx_ready` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | DFI clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_dis_auto | input | 1 | 1 stops the interval timer |
| cfg_dis_srx_upd | input | 1 | 1 suppresses self-refresh-exit updates |
| cfg_pre_srx | input | 1 | 1 = update before exit, 0 = after exit |
| cfg_t_min | input | TW | Minimum request hold, in cycles |
| cfg_t_max | input | TW | Maximum request hold, in cycles |
| sw_upd | input | 1 | One-cycle software update command |
| srx_exit_req | input | 1 | Pulse: self-refresh exit is about to start |
| srx_done | input | 1 | Pulse: self-refresh exit has completed |
| phy_ack | input | 1 | PHY update acknowledge |
| upd_req | output | 1 | Update request toward the PHY |
| upd_timeout | output | 1 | One-cycle pulse for an unacknowledged handshake |
| srx_ready | output | 1 | Low while a before-exit update is outstanding |

## Verification
The bench sweeps several minimum times against a set of acknowledge shapes:
- no acknowledge at all;
- short and long pulses;
- a pulse that starts exactly at the minimum boundary;
- a pulse that starts one cycle past it;
- an acknowledge that never drops.

For each shape it computes the request length arithmetically. A design off by one at the window edge would accept a late acknowledge or time out one cycle early or late. A design lacking the maximum cap would hold the request for as long as the acknowledge lasts. Other tests measure the spacing of periodic requests, the one-cycle gap before a held trigger is served, and the exact edges at which `srx_ready` falls and rises. A design that mixed up the before-exit and after-exit selections, or ignored the suppress bit, would start a request at the wrong pulse or leave the exit stalled.

// File: rtl/dfi_upd_pkg.sv
package dfi_upd_pkg;

  typedef enum logic {
    HS_IDLE   = 1'b0,
    HS_ACTIVE = 1'b1
  } hs_state_e;

  // Trigger sources for one handshake
  typedef struct packed {
    logic pre;   // before self-refresh exit
    logic post;  // after self-refresh exit
    logic gen;   // periodic timer or software
  } upd_src_t;

endpackage

// File: rtl/dfi_upd_interval.sv
module dfi_upd_interval #(
  parameter int unsigned INTERVAL = 4096
) (
  input  logic clk,
  input  logic rst,
  input  logic en_i,
  output logic tick_o
);
  localparam int unsigned TMW = (INTERVAL > 2) ? $clog2(INTERVAL) : 1;
  localparam logic [TMW-1:0] LAST = TMW'(INTERVAL - 1);

  logic [TMW-1:0] tmr_q;

  assign tick_o = en_i && (tmr_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || !en_i) begin
      tmr_q <= '0;
    end else if (tmr_q == LAST) begin
      tmr_q <= '0;
    end else begin
      tmr_q <= tmr_q + 1'b1;
    end
  end

  AST_TICK_SPACING: assert property (@(posedge clk) disable iff (rst)
    tick_o |=> !tick_o); // R7

endmodule

// File: rtl/dfi_upd_handshake.sv
module dfi_upd_handshake
  import dfi_upd_pkg::*;
#(
  parameter int TW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic          ack_i,
  input  logic [TW-1:0] t_min_i,
  input  logic [TW-1:0] t_max_i,
  output logic          req_o,
  output logic          done_o,
  output logic          timeout_o
);
  localparam int CW = TW + 2;

  hs_state_e     state_q;
  logic [CW-1:0] cnt_q;
  logic          acked_q;
  logic          timeout_q;

  logic [CW-1:0] lo, hi, lo2;
  logic          in_win, acked_now, at_max, finish;

  always_comb begin
    lo        = CW'(t_min_i);
    hi        = CW'(t_max_i);
    lo2       = lo + CW'(2);
    in_win    = ack_i && (cnt_q <= lo);
    acked_now = acked_q || in_win;
    at_max    = cnt_q >= hi;
    finish    = (state_q == HS_ACTIVE) &&
                (at_max || (acked_now ? (!ack_i && (cnt_q >= lo))
                                      : (cnt_q >= lo2)));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= HS_IDLE;
      cnt_q     <= '0;
      acked_q   <= 1'b0;
      timeout_q <= 1'b0;
    end else begin
      timeout_q <= finish && !acked_now;
      case (state_q)
        HS_IDLE: begin
          if (start_i) begin
            state_q <= HS_ACTIVE;
            cnt_q   <= CW'(1);
            acked_q <= 1'b0;
          end
        end
        default: begin
          if (finish) begin
            state_q <= HS_IDLE;
            cnt_q   <= '0;
            acked_q <= 1'b0;
          end else begin
            cnt_q   <= cnt_q + 1'b1;
            acked_q <= acked_now;
          end
        end
      endcase
    end
  end

  assign req_o     = (state_q == HS_ACTIVE);
  assign done_o    = finish;
  assign timeout_o = timeout_q;

  AST_TIMEOUT_AFTER_FALL: assert property (@(posedge clk) disable iff (rst)
    timeout_q |-> (!req_o && $past(req_o))); // R3
  AST_TIMEOUT_LEN: assert property (@(posedge clk) disable iff (rst)
    (timeout_q && (hi >= lo2)) |-> ($past(cnt_q) == lo2)); // R3
  AST_REQ_MAX: assert property (@(posedge clk) disable iff (rst)
    req_o |-> (cnt_q <= hi)); // R5
  AST_MIN_HOLD: assert property (@(posedge clk) disable iff (rst)
    $fell(req_o) |-> (($past(cnt_q) >= lo) || ($past(cnt_q) >= hi))); // R4

endmodule

// File: rtl/dfi_upd_source.sv
module dfi_upd_source
  import dfi_upd_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic dis_srx_i,
  input  logic pre_srx_i,
  input  logic gen_i,
  input  logic srx_exit_req_i,
  input  logic srx_done_i,
  input  logic busy_i,
  input  logic hs_done_i,
  output logic start_o,
  output logic srx_ready_o
);
  upd_src_t new_src, pend_q, want;
  logic     serving_pre_q;
  logic     srx_ready_q;

  always_comb begin
    new_src.gen  = gen_i;
    new_src.pre  = srx_exit_req_i && !dis_srx_i && pre_srx_i;
    new_src.post = srx_done_i && !dis_srx_i && !pre_srx_i;
    want         = pend_q | new_src;
    start_o      = !busy_i && (|want);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q        <= '0;
      serving_pre_q <= 1'b0;
      srx_ready_q   <= 1'b1;
    end else begin
      if (start_o) begin
        pend_q        <= '0;
        serving_pre_q <= want.pre;
      end else begin
        pend_q <= want;
        if (hs_done_i) serving_pre_q <= 1'b0;
      end
      if (new_src.pre) begin
        srx_ready_q <= 1'b0;
      end else if (hs_done_i && serving_pre_q && !pend_q.pre) begin
        srx_ready_q <= 1'b1;
      end
    end
  end

  assign srx_ready_o = srx_ready_q;

  AST_READY_FALL_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $fell(srx_ready_o) |-> $past(srx_exit_req_i && !dis_srx_i && pre_srx_i)); // R10
  AST_READY_RISE_AT_END: assert property (@(posedge clk) disable iff (rst)
    $rose(srx_ready_o) |-> $past(hs_done_i)); // R10

endmodule

// File: rtl/dfi_upd_seq.sv
module dfi_upd_seq
  import dfi_upd_pkg::*;
#(
  parameter int unsigned UPD_INTERVAL = 4096,
  parameter int          TW           = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_dis_auto,
  input  logic          cfg_dis_srx_upd,
  input  logic          cfg_pre_srx,
  input  logic [TW-1:0] cfg_t_min,
  input  logic [TW-1:0] cfg_t_max,
  input  logic          sw_upd,
  input  logic          srx_exit_req,
  input  logic          srx_done,
  input  logic          phy_ack,
  output logic          upd_req,
  output logic          upd_timeout,
  output logic          srx_ready
);
  logic tick, gen, start, hs_done, req_int;

  dfi_upd_interval #(.INTERVAL(UPD_INTERVAL)) u_interval (
    .clk    (clk),
    .rst    (rst),
    .en_i   (!cfg_dis_auto),
    .tick_o (tick)
  );

  assign gen = tick || sw_upd;

  dfi_upd_source u_source (
    .clk            (clk),
    .rst            (rst),
    .dis_srx_i      (cfg_dis_srx_upd),
    .pre_srx_i      (cfg_pre_srx),
    .gen_i          (gen),
    .srx_exit_req_i (srx_exit_req),
    .srx_done_i     (srx_done),
    .busy_i         (req_int),
    .hs_done_i      (hs_done),
    .start_o        (start),
    .srx_ready_o    (srx_ready)
  );

  dfi_upd_handshake #(.TW(TW)) u_handshake (
    .clk       (clk),
    .rst       (rst),
    .start_i   (start),
    .ack_i     (phy_ack),
    .t_min_i   (cfg_t_min),
    .t_max_i   (cfg_t_max),
    .req_o     (req_int),
    .done_o    (hs_done),
    .timeout_o (upd_timeout)
  );

  assign upd_req = req_int;

  AST_SW_START: assert property (@(posedge clk) disable iff (rst)
    (sw_upd && !upd_req) |=> upd_req); // R2
  AST_POST_SRX_START: assert property (@(posedge clk) disable iff (rst)
    (srx_done && !cfg_dis_srx_upd && !cfg_pre_srx && !upd_req) |=> upd_req); // R11
  AST_SRX_DISABLED_READY: assert property (@(posedge clk) disable iff (rst)
    (cfg_dis_srx_upd && $past(cfg_dis_srx_upd) && $past(srx_ready)) |-> srx_ready); // R12

endmodule

// File: tb/dfi_upd_seq_tb.sv
module dfi_upd_seq_tb;
  localparam int TW = 10;
  localparam int IVL = 100;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_dis_auto = 1'b1, cfg_dis_srx_upd = 1'b0, cfg_pre_srx = 1'b0;
  logic [TW-1:0] cfg_t_min = 10'd3, cfg_t_max = 10'd64;
  logic sw_upd = 1'b0, srx_exit_req = 1'b0, srx_done = 1'b0, phy_ack = 1'b0;
  logic upd_req, upd_timeout, srx_ready;

  int checks = 0, fails = 0, cyc = 0;

  always #10 clk = ~clk;

  dfi_upd_seq #(.UPD_INTERVAL(IVL), .TW(TW)) u_dut (
    .clk(clk), .rst(rst), .cfg_dis_auto(cfg_dis_auto),
    .cfg_dis_srx_upd(cfg_dis_srx_upd), .cfg_pre_srx(cfg_pre_srx),
    .cfg_t_min(cfg_t_min), .cfg_t_max(cfg_t_max), .sw_upd(sw_upd),
    .srx_exit_req(srx_exit_req), .srx_done(srx_done), .phy_ack(phy_ack),
    .upd_req(upd_req), .upd_timeout(upd_timeout), .srx_ready(srx_ready)
  );

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", rq, act, exp, cyc);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic wait_idle();
    while (upd_req) @(negedge clk);
    @(negedge clk);
  endtask

  function automatic int exp_len(input int a, input int l, input int mn, input int mx);
    int d;
    if (a >= 1 && a <= mn) d = (mn > a + l) ? mn : a + l;
    else d = mn + 2;
    return (d < mx) ? d : mx;
  endfunction

  // Software-started handshake; ack high during request cycles a..a+l-1 (a=0: none)
  task automatic run_hs(input int a, input int l, input int mn, input int mx);
    int k;
    bit to_exp;
    cfg_t_min = TW'(mn); cfg_t_max = TW'(mx);
    sw_upd = 1'b1;
    @(negedge clk);
    sw_upd = 1'b0;
    chk(upd_req == 1'b1, "R2 req rises after sw pulse", upd_req, 1);
    k = 1;
    while (1) begin
      phy_ack = (a > 0) && (k >= a) && (k < a + l);
      @(negedge clk);
      if (!upd_req || k > 2000) break;
      k++;
    end
    phy_ack = 1'b0;
    to_exp = !((a >= 1) && (a <= mn));
    if (a > mn) chk(k == exp_len(a, l, mn, mx), "R6 late ack ignored, length", k, exp_len(a, l, mn, mx));
    else if (a == 0) chk(k == exp_len(a, l, mn, mx), "R3 no-ack length", k, exp_len(a, l, mn, mx));
    else if (a + l > mx) chk(k == exp_len(a, l, mn, mx), "R5 capped length", k, exp_len(a, l, mn, mx));
    else chk(k == exp_len(a, l, mn, mx), "R4 acked length", k, exp_len(a, l, mn, mx));
    chk(upd_timeout == to_exp, "R3 timeout pulse value", upd_timeout, to_exp);
    @(negedge clk);
    chk(upd_timeout == 1'b0, "R3 timeout one cycle", upd_timeout, 0);
  endtask

  initial begin
    int mins[3] = '{3, 5, 8};
    int rises[4];
    int nr, k;
    bit seen;

    repeat (3) @(negedge clk);
    chk(upd_req == 1'b0 && upd_timeout == 1'b0 && srx_ready == 1'b1, "R1 reset state",
        {upd_req, upd_timeout, srx_ready}, 1);
    rst = 1'b0;
    @(negedge clk);
    chk(upd_req == 1'b0 && upd_timeout == 1'b0 && srx_ready == 1'b1, "R1 after reset",
        {upd_req, upd_timeout, srx_ready}, 1);

    // Sweep minimum times against acknowledge shapes
    foreach (mins[i]) begin
      int mn;
      mn = mins[i];
      run_hs(0, 0, mn, 64);
      run_hs(1, 1, mn, 64);
      run_hs(1, 10, mn, 64);
      run_hs(2, 2, mn, 64);
      run_hs(mn, 1, mn, 64);
      run_hs(mn + 1, 3, mn, 64);
      run_hs(2, 200, mn, 64);
      wait_idle();
    end
    run_hs(1, 300, 3, 70);
    wait_idle();

    // R9: trigger during an active handshake
    cfg_t_min = 10'd4; cfg_t_max = 10'd64;
    sw_upd = 1'b1; @(negedge clk); sw_upd = 1'b0;
    @(negedge clk);
    sw_upd = 1'b1; @(negedge clk); sw_upd = 1'b0;
    while (upd_req) @(negedge clk);
    chk(upd_req == 1'b0, "R9 one-cycle gap low", upd_req, 0);
    @(negedge clk);
    chk(upd_req == 1'b1, "R9 held trigger served", upd_req, 1);
    wait_idle();

    // R7: periodic requests
    cfg_dis_auto = 1'b0;
    nr = 0; seen = 1'b0; k = 0;
    while (nr < 4 && k < 1000) begin
      @(negedge clk);
      k++;
      if (upd_req && !seen) begin rises[nr] = k; nr++; end
      seen = upd_req;
    end
    chk(nr == 4, "R7 periodic requests seen", nr, 4);
    for (int j = 1; j < 4; j++)
      chk(rises[j] - rises[j-1] == IVL, "R7 periodic spacing", rises[j] - rises[j-1], IVL);
    cfg_dis_auto = 1'b1;
    wait_idle();

    // R8: disabled timer stays silent
    seen = 1'b0;
    repeat (3 * IVL + 20) begin
      @(negedge clk);
      if (upd_req) seen = 1'b1;
    end
    chk(!seen, "R8 no request with timer off", seen, 0);

    // R10: update before self-refresh exit
    cfg_pre_srx = 1'b1; cfg_dis_srx_upd = 1'b0; cfg_t_min = 10'd4;
    srx_exit_req = 1'b1; @(negedge clk); srx_exit_req = 1'b0;
    chk(srx_ready == 1'b0, "R10 ready low", srx_ready, 0);
    chk(upd_req == 1'b1, "R10 request started", upd_req, 1);
    k = 1; seen = 1'b0;
    while (1) begin
      @(negedge clk);
      if (!upd_req || k > 100) break;
      if (srx_ready) seen = 1'b1;
      k++;
    end
    chk(!seen, "R10 ready held low during request", seen, 0);
    chk(k == 6, "R10 pre-exit request length", k, 6);
    chk(srx_ready == 1'b1, "R10 ready rises with request fall", srx_ready, 1);
    wait_idle();

    // R11: update after self-refresh exit
    cfg_pre_srx = 1'b0;
    srx_exit_req = 1'b1; @(negedge clk); srx_exit_req = 1'b0;
    chk(srx_ready == 1'b1, "R11 ready unaffected", srx_ready, 1);
    seen = 1'b0;
    repeat (5) begin @(negedge clk); if (upd_req) seen = 1'b1; end
    chk(!seen, "R11 no request before done", seen, 0);
    srx_done = 1'b1; @(negedge clk); srx_done = 1'b0;
    chk(upd_req == 1'b1, "R11 request after done", upd_req, 1);
    wait_idle();

    // R12: exit updates suppressed, select ignored
    cfg_dis_srx_upd = 1'b1;
    for (int p = 0; p < 2; p++) begin
      cfg_pre_srx = p[0];
      seen = 1'b0;
      srx_exit_req = 1'b1; @(negedge clk); srx_exit_req = 1'b0;
      if (upd_req || !srx_ready) seen = 1'b1;
      repeat (3) begin @(negedge clk); if (upd_req || !srx_ready) seen = 1'b1; end
      srx_done = 1'b1; @(negedge clk); srx_done = 1'b0;
      repeat (8) begin @(negedge clk); if (upd_req || !srx_ready) seen = 1'b1; end
      chk(!seen, "R12 suppressed exit update", seen, 0);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule